// File: doc/BRIEF.md
# Scaled-Reliability Hard Decision Combiner

This block sits between the bounded-distance component decoder and the decision-matrix storage of an iterative product-code decoder. It processes one whole row or column word per transfer. For every bit position it receives several inputs: the stored quantized channel log-likelihood ratio, the bit the component decoder produced, a single success flag for the word, and the hard decision that entered the component decoder. From these it forms the one-bit message that is written back for the orthogonal decoders.

In scaled-reliability mode the decoder result is turned into a ternary value. A decoded 0 becomes +1, a decoded 1 becomes -1, and a failed word gives 0 for every position. That value is multiplied by a weight, added to the channel LLR, and the sign of the sum gives the outgoing bit. The weight comes from a fixed table indexed by the half-iteration number, where one half-iteration is one row pass or one column pass. A mode input switches to plain bounded-distance decisions, which ignore the LLR. This mode is used for the last few iterations to clear errors caused by confident channel bits with the wrong sign.

Top module: `srhd_combiner`

## Requirements
- R1: After reset, out_valid is 0 and in_ready is 1.
- R2: In scaled mode (plain_mode = 0), the ternary term for each position is +1 if decode_ok = 1 and the decoded bit is 0, -1 if decode_ok = 1 and the decoded bit is 1, and 0 if decode_ok = 0. Position i outputs 1 exactly when the sum llr_i + w·term_i is negative, and 0 otherwise.
- R3: A sum of exactly zero gives output bit 0.
- R4: In scaled mode with decode_ok = 0, position i outputs 1 exactly when llr_i is negative.
- R5: The weight w is table entry half_idx. The default table for indices 0..7 is 3, 4, 6, 7, 8, 10, 12, 15.
- R6: In plain mode with decode_ok = 1, every output bit equals the decoded bit, whatever the LLR.
- R7: In plain mode with decode_ok = 0, every output bit equals the incoming hard decision bit.
- R8: A word accepted on a clock edge (in_valid and in_ready both 1) appears on out_bits with out_valid = 1 after that same edge, which is one cycle of latency.
- R9: While out_valid = 1 and out_ready = 0, out_bits and out_valid hold and in_ready is 0. When out_ready returns to 1, a new word can be accepted on the same edge that drains the held one.
- R10: The sum is formed two bits wider than its operands. Extreme values such as llr = +15 with w = 15 and term +1 (sum 30) never wrap to the wrong sign.
- R11: Each LLR is a 5-bit two's-complement value in llr[5i+4:5i]. The decoded bit, hard bit and output bit of position i are bit i of their vectors.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input word present |
| in_ready | output | 1 | Block can accept a word |
| llr | input | N_POS*LLR_W | Channel LLR per position, 5 bits each |
| dec_bits | input | N_POS | Component decoder output bits |
| decode_ok | input | 1 | Component decode succeeded for this word |
| hard_bits | input | N_POS | Hard decisions that entered the decoder |
| half_idx | input | HALF_W | Half-iteration number selecting the weight |
| plain_mode | input | 1 | 1 selects plain bounded-distance decisions |
| out_valid | output | 1 | Output word present |
| out_ready | input | 1 | Downstream accepts the output word |
| out_bits | output | N_POS | Binary messages for the orthogonal decoders |

## Verification
The combining path has no internal pipeline, so an output word is due exactly one clock edge after it is accepted. The bench drives each word on a falling edge and checks it at the next falling edge, half a period after the capturing rising edge. For stalls, the bench keeps out_ready low and checks at several falling edges that the held word and in_ready stay unchanged. It then releases out_ready and expects the next queued word one edge later. Expected bits come from a bench function that evaluates the ternary sum with integer arithmetic.

// File: rtl/srhd_pkg.sv
package srhd_pkg;

    typedef enum logic [1:0] {
        TERN_ERASE = 2'b00,
        TERN_PLUS  = 2'b01,
        TERN_MINUS = 2'b10
    } tern_e;

    function automatic tern_e to_tern(input logic ok, input logic bit_val);
        if (!ok)
            return TERN_ERASE;
        return bit_val ? TERN_MINUS : TERN_PLUS;
    endfunction

endpackage

// File: rtl/srhd_weight_sel.sv
module srhd_weight_sel #(
    parameter int N_HALF  = 8,
    parameter int SCALE_W = 5,
    parameter logic [N_HALF*SCALE_W-1:0] SCALE_TABLE = '0,
    localparam int HALF_W = (N_HALF > 1) ? $clog2(N_HALF) : 1
) (
    input  logic [HALF_W-1:0]         half_idx,
    output logic signed [SCALE_W-1:0] weight
);

    logic signed [SCALE_W-1:0] entry [N_HALF];

    for (genvar k = 0; k < N_HALF; k++) begin : g_entry
        assign entry[k] = SCALE_TABLE[k*SCALE_W +: SCALE_W];
    end

    always_comb begin
        weight = entry[N_HALF-1];
        if (int'(half_idx) < N_HALF)
            weight = entry[half_idx];
    end

endmodule

// File: rtl/srhd_lane.sv
module srhd_lane
    import srhd_pkg::*;
#(
    parameter int LLR_W   = 5,
    parameter int SCALE_W = 5,
    localparam int SUM_W  = ((LLR_W > SCALE_W) ? LLR_W : SCALE_W) + 2
) (
    input  logic signed [LLR_W-1:0]   llr,
    input  logic signed [SCALE_W-1:0] weight,
    input  logic                      dec_bit,
    input  logic                      decode_ok,
    input  logic                      hard_bit,
    input  logic                      plain_mode,
    output logic                      out_bit
);

    tern_e                   tern;
    logic signed [SUM_W-1:0] llr_x;
    logic signed [SUM_W-1:0] w_x;
    logic signed [SUM_W-1:0] term;
    logic signed [SUM_W-1:0] rel;
    logic                    sr_bit;

    always_comb begin
        tern  = to_tern(decode_ok, dec_bit);
        llr_x = SUM_W'(llr);
        w_x   = SUM_W'(weight);
        unique case (tern)
            TERN_PLUS:  term = w_x;
            TERN_MINUS: term = -w_x;
            default:    term = '0;
        endcase
        rel    = llr_x + term;
        sr_bit = rel[SUM_W-1];
        if (plain_mode)
            out_bit = decode_ok ? dec_bit : hard_bit;
        else
            out_bit = sr_bit;
    end

    always_comb begin
        if (!plain_mode && !decode_ok)
            assert_erase_llr_sign_R4: assert (out_bit == llr[LLR_W-1]);
        if (plain_mode && decode_ok)
            assert_plain_decoded_R6: assert (out_bit == dec_bit);
        if (plain_mode && !decode_ok)
            assert_plain_pass_R7: assert (out_bit == hard_bit);
    end

endmodule

// File: rtl/srhd_combiner.sv
module srhd_combiner #(
    parameter int N_POS   = 8,
    parameter int LLR_W   = 5,
    parameter int SCALE_W = 5,
    parameter int N_HALF  = 8,
    parameter logic [N_HALF*SCALE_W-1:0] SCALE_TABLE =
        {5'd15, 5'd12, 5'd10, 5'd8, 5'd7, 5'd6, 5'd4, 5'd3},
    localparam int HALF_W = (N_HALF > 1) ? $clog2(N_HALF) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_valid,
    output logic                   in_ready,
    input  logic [N_POS*LLR_W-1:0] llr,
    input  logic [N_POS-1:0]       dec_bits,
    input  logic                   decode_ok,
    input  logic [N_POS-1:0]       hard_bits,
    input  logic [HALF_W-1:0]      half_idx,
    input  logic                   plain_mode,
    output logic                   out_valid,
    input  logic                   out_ready,
    output logic [N_POS-1:0]       out_bits
);

    typedef struct packed {
        logic             vld;
        logic [N_POS-1:0] bits;
    } state_t;

    state_t                    st_d, st_q;
    logic signed [SCALE_W-1:0] weight;
    logic [N_POS-1:0]          lane_bits;

    srhd_weight_sel #(
        .N_HALF      (N_HALF),
        .SCALE_W     (SCALE_W),
        .SCALE_TABLE (SCALE_TABLE)
    ) u_wsel (
        .half_idx (half_idx),
        .weight   (weight)
    );

    for (genvar i = 0; i < N_POS; i++) begin : g_lane
        srhd_lane #(
            .LLR_W   (LLR_W),
            .SCALE_W (SCALE_W)
        ) u_lane (
            .llr        (llr[i*LLR_W +: LLR_W]),
            .weight     (weight),
            .dec_bit    (dec_bits[i]),
            .decode_ok  (decode_ok),
            .hard_bit   (hard_bits[i]),
            .plain_mode (plain_mode),
            .out_bit    (lane_bits[i])
        );
    end

    assign in_ready  = !st_q.vld || out_ready;
    assign out_valid = st_q.vld;
    assign out_bits  = st_q.bits;

    always_comb begin
        st_d = st_q;
        if (st_q.vld && out_ready)
            st_d.vld = 1'b0;
        if (in_valid && in_ready) begin
            st_d.vld  = 1'b1;
            st_d.bits = lane_bits;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assert_accept_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> out_valid);

    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_bits)));

    assert_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !in_ready);

endmodule

// File: tb/srhd_combiner_test.sv
module srhd_combiner_test;

    localparam int N  = 8;
    localparam int LW = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [N*LW-1:0] llr = '0;
    logic [N-1:0]  dec_bits = '0;
    logic          decode_ok = 1'b0;
    logic [N-1:0]  hard_bits = '0;
    logic [2:0]    half_idx = '0;
    logic          plain_mode = 1'b0;
    logic          out_valid;
    logic          out_ready = 1'b1;
    logic [N-1:0]  out_bits;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 0;

    always #5 clk = ~clk;

    srhd_combiner uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .llr(llr), .dec_bits(dec_bits), .decode_ok(decode_ok),
        .hard_bits(hard_bits), .half_idx(half_idx), .plain_mode(plain_mode),
        .out_valid(out_valid), .out_ready(out_ready), .out_bits(out_bits)
    );

    function automatic int w_of(input int h);
        case (h)
            0: return 3;  1: return 4;  2: return 6;  3: return 7;
            4: return 8;  5: return 10; 6: return 12; default: return 15;
        endcase
    endfunction

    function automatic logic [N-1:0] expect_bits(
        input logic [N*LW-1:0] l, input logic [N-1:0] d, input logic ok,
        input logic [N-1:0] h, input logic [2:0] hi, input logic pm);
        logic [N-1:0] r;
        for (int i = 0; i < N; i++) begin
            int lv = int'($signed(l[i*LW +: LW]));
            int t = ok ? (d[i] ? -1 : 1) : 0;
            int s = lv + t * w_of(int'(hi));
            if (pm) r[i] = ok ? d[i] : h[i];
            else    r[i] = (s < 0);
        end
        return r;
    endfunction

    task automatic check(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic drive(input logic [N*LW-1:0] l, input logic [N-1:0] d, input logic ok,
                         input logic [N-1:0] h, input logic [2:0] hi, input logic pm);
        llr = l; dec_bits = d; decode_ok = ok; hard_bits = h;
        half_idx = hi; plain_mode = pm; in_valid = 1'b1;
    endtask

    task automatic send(input string req, input logic [N*LW-1:0] l, input logic [N-1:0] d,
                        input logic ok, input logic [N-1:0] h, input logic [2:0] hi, input logic pm);
        @(negedge clk);
        drive(l, d, ok, h, hi, pm);
        @(negedge clk);
        in_valid = 1'b0;
        check(req, {out_valid, out_bits}, {1'b1, expect_bits(l, d, ok, h, hi, pm)});
    endtask

    function automatic logic [N*LW-1:0] fill(input logic [LW-1:0] v);
        return {N{v}};
    endfunction

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_fail++; n_checks++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        logic [N*LW-1:0] la, lb;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset", {out_valid, in_ready}, 2'b01);

        // R3 tie: llr -6, term +1, weight 6 (half 2) -> 0; llr +6, term -1 -> 0
        send("R3 tie plus", fill(5'sd26), '0, 1'b1, '0, 3'd2, 1'b0);
        check("R3 tie plus value", out_bits, '0);
        send("R3 tie minus", fill(5'd6), '1, 1'b1, '0, 3'd2, 1'b0);
        check("R3 tie minus value", out_bits, '0);
        send("R2 just below", fill(5'd25), '0, 1'b1, '0, 3'd2, 1'b0);
        check("R2 just below value", out_bits, '1);

        // R5 weight selection: llr -5, decoded 0
        send("R5 half0", fill(5'd27), '0, 1'b1, '0, 3'd0, 1'b0);
        check("R5 half0 value", out_bits, '1);
        send("R5 half2", fill(5'd27), '0, 1'b1, '0, 3'd2, 1'b0);
        check("R5 half2 value", out_bits, '0);
        send("R5 half7", fill(5'd17), '0, 1'b1, '0, 3'd7, 1'b0);
        check("R5 half7 value", out_bits, '0);

        // R10 extremes
        send("R10 pos extreme", fill(5'd15), '0, 1'b1, '0, 3'd7, 1'b0);
        check("R10 pos value", out_bits, '0);
        send("R10 neg extreme", fill(5'd16), '1, 1'b1, '1, 3'd7, 1'b0);
        check("R10 neg value", out_bits, '1);

        // R4 erased word follows llr sign, R11 positions
        la = '0;
        for (int i = 0; i < N; i++) la[i*LW +: LW] = (i % 2) ? 5'd31 : 5'd1;
        send("R4 R11 erased", la, 8'hFF, 1'b0, 8'h00, 3'd7, 1'b0);
        check("R4 erased value", out_bits, 8'hAA);

        // R6 / R7 plain mode
        send("R6 plain decoded", fill(5'd15), 8'hC3, 1'b1, 8'h0F, 3'd7, 1'b1);
        check("R6 plain value", out_bits, 8'hC3);
        send("R7 plain passthrough", fill(5'd16), 8'hFF, 1'b0, 8'h5A, 3'd7, 1'b1);
        check("R7 plain value", out_bits, 8'h5A);

        // R9 backpressure and R8 refill on drain edge
        la = fill(5'd3);
        lb = fill(5'd29);
        @(negedge clk);
        out_ready = 1'b0;
        drive(la, '1, 1'b0, '0, 3'd1, 1'b0);
        @(negedge clk);
        check("R8 held A", {out_valid, out_bits}, {1'b1, 8'h00});
        check("R9 stall ready", {1'b0, in_ready}, 2'b00);
        drive(lb, '1, 1'b0, '0, 3'd1, 1'b0);
        @(negedge clk);
        check("R9 hold A", {out_valid, out_bits}, {1'b1, 8'h00});
        @(negedge clk);
        check("R9 hold A again", {out_valid, out_bits}, {1'b1, 8'h00});
        out_ready = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check("R9 R8 next B", {out_valid, out_bits}, {1'b1, 8'hFF});
        @(negedge clk);
        check("R8 drained", {1'b0, out_valid}, 2'b00);

        // R2 R6 R7 random
        void'($urandom(32'd1234));
        for (int k = 0; k < 400; k++) begin
            logic [N*LW-1:0] rl;
            for (int i = 0; i < N; i++) rl[i*LW +: LW] = LW'($urandom);
            send((k % 4 == 3) ? "R6 R7 random plain" : "R2 random scaled", rl,
                 N'($urandom), ($urandom % 3) != 0, N'($urandom),
                 3'($urandom), (k % 4 == 3));
        end

        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule